// File: doc/BRIEF.md
# SWD host transaction engine

This block is the host side of a two-wire serial debug link. It carries out exactly one debug-port or access-port register access for each command it accepts. A command names the port type, the direction, a two-bit register address and, for a write, a 32-bit data word. The engine serializes the 8-bit request header and releases the data line for the turnaround cycles. It collects the target's 3-bit acknowledge. When that acknowledge is OK, it either drives the 33-bit write data phase or samples the 33-bit read data phase. It then reports the outcome on a one-cycle response strobe.

The engine runs on the system clock and divides it into bit slots of `CLK_DIV` cycles each. `swclk_en` is high for every cycle of a transaction, so an external gate can pulse SWCLK once per slot. The host changes `swdio_o` and `swdio_oe` only at slot boundaries. It samples `swdio_i` at the clock edge that closes a slot. Retry on WAIT, recovery from FAULT and line reset sequences belong to the layer above.

Slots are numbered from 0, the first slot after the command is taken. For an OK acknowledge a transaction lasts 46 slots. For any other acknowledge it lasts 13 slots.

Top module: `swd_txn_engine`

## Requirements
- R1: `cmd_ready` is 1 only while no transaction is in progress. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both 1. `cmd_ready` drops in the cycle after that and returns to 1 in the same cycle as the response strobe.
- R2: In slots 0 to 7 the host drives the line (`swdio_oe`=1) with, in order: 1, `cmd_ap`, `cmd_rnw`, `cmd_addr[0]`, `cmd_addr[1]`, the request parity, 0, 1. `cmd_ap`=1 means access port and `cmd_rnw`=1 means read.
- R3: The request parity bit is 1 exactly when `cmd_ap`, `cmd_rnw`, `cmd_addr[0]` and `cmd_addr[1]` together hold an odd number of ones.
- R4: Slot 8 is a turnaround with `swdio_oe`=0. In slots 9, 10 and 11 the host samples the acknowledge, and the first sampled bit becomes `rsp_ack[0]`. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R5: For a write with an OK acknowledge, slot 12 is a turnaround with `swdio_oe`=0. In slots 13 to 44 the host drives `cmd_wdata` LSB first, and in slot 45 it drives the XOR of all data bits, all with `swdio_oe`=1.
- R6: For a read with an OK acknowledge, the host samples slots 12 to 44 with `swdio_oe`=0. These hold the data LSB first, then the parity. Slot 45 is a turnaround with `swdio_oe`=0, and `rsp_rdata` returns the sampled data.
- R7: `rsp_perr` is 1 only on an OK read whose sampled parity differs from the XOR of the sampled data. The data is still returned when it is set.
- R8: On WAIT or FAULT there is no data phase. Slot 12 is a turnaround with `swdio_oe`=0, and `rsp_rdata` is 0.
- R9: An acknowledge other than the three legal codes sets `rsp_proto_err` and is handled as in R8. `rsp_proto_err` is 0 for legal codes.
- R10: Every slot lasts `CLK_DIV` cycles and `swdio_o` is constant within a slot. `swclk_en` is 1 for exactly slots×`CLK_DIV` cycles. `rsp_valid` is a one-cycle pulse in the cycle after the last of those cycles.
- R11: After reset `cmd_ready`=1, `swclk_en`=0, `swdio_oe`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ack | output | 3 | Acknowledge as received, first bit in bit 0 |
| rsp_rdata | output | DATA_W | Read data, 0 unless an OK read |
| rsp_perr | output | 1 | Read data parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was not a legal code |
| swdio_o | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drives the data line |
| swdio_i | input | 1 | Data line value seen by the host |
| swclk_en | output | 1 | One SWCLK pulse per slot while high |

## Verification
Some properties are checked by assertions on every cycle. The request header holds its fixed bits and even parity over bits 1 to 5. The data line is held steady within a slot, and the enable changes only at slot boundaries. The response strobe lasts one cycle and comes right after clocking stops. A parity error never appears without an OK acknowledge, and a protocol error returns no data. Other behaviour can only be shown by the bench's scenarios, which play the target. These cover the exact slot placement of the header, the turnarounds and the data bits, and the LSB-first assembly of acknowledge and read data. They also cover the different slot counts for OK, WAIT, FAULT and illegal acknowledges, and the parity flag under corrupted read parity.

// File: rtl/swd_pkg.sv
// Shared constants and types for the serial-wire debug host engine.
// Assumes a 3-bit acknowledge received first-bit-in-bit-0.
package swd_pkg;
    localparam int REQ_BITS = 8;
    localparam int ACK_BITS = 3;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_TRN_A,
        PH_ACK,
        PH_TRN_W,
        PH_WDAT,
        PH_RDAT,
        PH_TRN_E
    } swd_phase_e;

    function automatic logic ack_legal(input logic [2:0] a);
        return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
    endfunction
endpackage

// File: rtl/swd_bit_timer.sv
// Bit-slot timer: while run is high, pulses slot_end on the last system
// cycle of each CLK_DIV-cycle slot. Assumes run rises on a slot boundary.
module swd_bit_timer #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end
);
    generate
        if (CLK_DIV <= 1) begin : g_direct
            assign slot_end = run;
        end else begin : g_count
            localparam int CW = $clog2(CLK_DIV);
            localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
            logic [CW-1:0] cnt;

            // Count cycles within the current slot, restart when idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign slot_end = run && (cnt == LAST);

            p_slot_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                slot_end |=> !slot_end);
        end
    endgenerate
endmodule

// File: rtl/swd_req_fmt.sv
// Request header builder: packs port select, direction and address into
// the 8-bit header, bit 0 sent first. Purely combinational.
module swd_req_fmt (
    input  logic       ap,
    input  logic       rnw,
    input  logic [1:0] addr,
    output logic [7:0] hdr
);
    logic par;

    // Odd-count parity over the four variable header fields.
    always_comb begin
        par = ap ^ rnw ^ addr[0] ^ addr[1];
        hdr = {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
    end

    // Header framing and even parity across bits 1..5 (R2, R3).
    always_comb begin
        if (!$isunknown({ap, rnw, addr})) begin
            p_hdr_frame_r2: assert (hdr[0] && !hdr[6] && hdr[7]);
            p_hdr_parity_r3: assert ((^hdr[5:1]) == 1'b0);
        end
    end
endmodule

// File: rtl/swd_seq.sv
// Transaction sequencer: walks request, turnaround, acknowledge, data and
// closing turnaround slots, shifting bits on slot_end. Assumes slot_end
// pulses once per slot while run is high.
module swd_seq
    import swd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_rnw,
    input  logic [7:0]        hdr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              run,
    output logic              rsp_valid,
    output logic [2:0]        rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    output logic              rsp_proto_err,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(REQ_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);

    swd_phase_e        phase;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        req_sh;
    logic [DATA_W:0]   wd_sh;
    logic [DATA_W:0]   rd_sh;
    logic [2:0]        ack_sh;
    logic [2:0]        ack_nxt;
    logic              rnw_q;
    logic              accept;
    logic              finish;

    assign accept  = cmd_valid && (phase == PH_IDLE);
    assign ack_nxt = {swdio_i, ack_sh[2:1]};
    assign finish  = slot_end && ((phase == PH_TRN_E) ||
                     ((phase == PH_WDAT) && (cnt == DATA_LAST)));

    // Phase and slot counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (accept) begin
            phase <= PH_REQ;
            cnt   <= '0;
        end else if (slot_end) begin
            cnt <= cnt + 1'b1;
            unique case (phase)
                PH_REQ:   if (cnt == REQ_LAST) begin phase <= PH_TRN_A; cnt <= '0; end
                PH_TRN_A: begin phase <= PH_ACK; cnt <= '0; end
                PH_ACK:   if (cnt == ACK_LAST) begin
                              cnt <= '0;
                              if (ack_nxt != ACK_OK) phase <= PH_TRN_E;
                              else if (rnw_q)         phase <= PH_RDAT;
                              else                    phase <= PH_TRN_W;
                          end
                PH_TRN_W: begin phase <= PH_WDAT; cnt <= '0; end
                PH_WDAT:  if (cnt == DATA_LAST) begin phase <= PH_IDLE; cnt <= '0; end
                PH_RDAT:  if (cnt == DATA_LAST) begin phase <= PH_TRN_E; cnt <= '0; end
                PH_TRN_E: begin phase <= PH_IDLE; cnt <= '0; end
                default:  begin phase <= PH_IDLE; cnt <= '0; end
            endcase
        end
    end

    // Shift registers for header out, write data out, acknowledge and read data in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sh <= '0;
            wd_sh  <= '0;
            rd_sh  <= '0;
            ack_sh <= '0;
            rnw_q  <= 1'b0;
        end else if (accept) begin
            req_sh <= hdr;
            wd_sh  <= {^cmd_wdata, cmd_wdata};
            rd_sh  <= '0;
            ack_sh <= '0;
            rnw_q  <= cmd_rnw;
        end else if (slot_end) begin
            if (phase == PH_REQ)  req_sh <= req_sh >> 1;
            if (phase == PH_WDAT) wd_sh  <= wd_sh >> 1;
            if (phase == PH_ACK)  ack_sh <= ack_nxt;
            if (phase == PH_RDAT) rd_sh  <= {swdio_i, rd_sh[DATA_W:1]};
        end
    end

    // Response capture at the close of the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            rsp_perr      <= 1'b0;
            rsp_proto_err <= 1'b0;
        end else begin
            rsp_valid <= finish;
            if (finish) begin
                if (rnw_q && (ack_sh == ACK_OK)) begin
                    rsp_rdata <= rd_sh[DATA_W-1:0];
                    rsp_perr  <= (^rd_sh[DATA_W-1:0]) != rd_sh[DATA_W];
                end else begin
                    rsp_rdata <= '0;
                    rsp_perr  <= 1'b0;
                end
                rsp_proto_err <= !ack_legal(ack_sh);
            end
        end
    end

    // Pin and handshake outputs decoded from the phase.
    always_comb begin
        cmd_ready = (phase == PH_IDLE);
        run       = (phase != PH_IDLE);
        swdio_oe  = (phase == PH_REQ) || (phase == PH_WDAT);
        swdio_o   = (phase == PH_REQ)  ? req_sh[0] :
                    (phase == PH_WDAT) ? wd_sh[0]  : 1'b0;
    end
    assign rsp_ack = ack_sh;

    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && swdio_oe && swdio_o));
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_after_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(run) && !run));
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(slot_end)) |-> ($stable(swdio_o) && $stable(swdio_oe)));
    p_perr_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perr) |-> (rsp_ack == ACK_OK));
    p_proto_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_proto_err) |-> (rsp_rdata == '0 && !rsp_perr));
endmodule

// File: rtl/swd_txn_engine.sv
// Serial-wire debug host transaction engine, one register access per
// command. Assumes an external gate turns swclk_en into one SWCLK pulse
// per slot and a pad combines swdio_o/swdio_oe/swdio_i.
module swd_txn_engine #(
    parameter int CLK_DIV = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_ap,
    input  logic              cmd_rnw,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    output logic              rsp_proto_err,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i,
    output logic              swclk_en
);
    logic [7:0] hdr;
    logic       run;
    logic       slot_end;

    swd_req_fmt u_fmt (
        .ap   (cmd_ap),
        .rnw  (cmd_rnw),
        .addr (cmd_addr),
        .hdr  (hdr)
    );

    swd_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .slot_end (slot_end)
    );

    swd_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_end      (slot_end),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_rnw       (cmd_rnw),
        .hdr           (hdr),
        .cmd_wdata     (cmd_wdata),
        .run           (run),
        .rsp_valid     (rsp_valid),
        .rsp_ack       (rsp_ack),
        .rsp_rdata     (rsp_rdata),
        .rsp_perr      (rsp_perr),
        .rsp_proto_err (rsp_proto_err),
        .swdio_o       (swdio_o),
        .swdio_oe      (swdio_oe),
        .swdio_i       (swdio_i)
    );

    assign swclk_en = run;

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!swclk_en && !swdio_oe));
endmodule

// File: tb/swd_txn_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: plays the debug target per slot, checks every response and the
// slot-by-slot pin activity against values computed from the requirements.
module swd_txn_engine_tb_top;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_ap = 1'b0;
    logic        cmd_rnw = 1'b0;
    logic [1:0]  cmd_addr = 2'b00;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        rsp_perr;
    logic        rsp_proto_err;
    logic        swdio_o;
    logic        swdio_oe;
    logic        swdio_i = 1'b0;
    logic        swclk_en;

    int n_checks = 0;
    int n_fail   = 0;

    // Target model state
    logic [2:0]  t_ack = 3'b001;
    logic [31:0] t_rdata = '0;
    logic        t_rpar = 1'b0;
    logic        t_read = 1'b0;
    int          en_cnt = 0;
    logic        obs_o  [0:63];
    logic        obs_oe [0:63];

    always #2.5 clk = ~clk;

    swd_txn_engine #(.CLK_DIV(DIV), .DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .rsp_perr(rsp_perr), .rsp_proto_err(rsp_proto_err),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i), .swclk_en(swclk_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input logic [2:0] a);
        return (a == 3'b001) || (a == 3'b010) || (a == 3'b100);
    endfunction

    function automatic logic tgt_bit(input int s);
        if (s >= 9 && s <= 11) return t_ack[s-9];
        if (t_read && t_ack == 3'b001 && s >= 12 && s <= 43) return t_rdata[s-12];
        if (t_read && t_ack == 3'b001 && s == 44) return t_rpar;
        return 1'($urandom % 2);
    endfunction

    // Target side: record host pins per slot and drive the line.
    always @(negedge clk) begin
        if (swclk_en) begin
            int s;
            s = en_cnt / DIV;
            if (s < 64) begin
                obs_o[s]  = swdio_o;
                obs_oe[s] = swdio_oe;
            end
            swdio_i = tgt_bit(s);
            en_cnt++;
        end
    end

    task automatic run_txn(input bit ap, input bit rnw, input logic [1:0] addr,
                           input logic [31:0] wd, input logic [2:0] ack,
                           input logic [31:0] rd, input bit bad_par);
        bit   ok;
        int   slots;
        int   guard;
        logic [7:0] exp_hdr;
        logic par;
        ok    = (ack == 3'b001);
        slots = ok ? 46 : 13;
        par   = ap ^ rnw ^ addr[0] ^ addr[1];
        exp_hdr = {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
        t_read = rnw; t_ack = ack; t_rdata = rd; t_rpar = (^rd) ^ bad_par;
        en_cnt = 0;
        for (int k = 0; k < 64; k++) begin obs_o[k] = 1'bx; obs_oe[k] = 1'bx; end
        cmd_ap = ap; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd; cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, "R1 ready before command", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R1 busy after accept", 64'(cmd_ready), 64'd0);
        guard = 0;
        while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
        chk(rsp_valid == 1'b1, "R10 response arrives", 64'(rsp_valid), 64'd1);
        chk(en_cnt == slots * DIV, "R10 clock-enable length", 64'(en_cnt), 64'(slots * DIV));
        chk(cmd_ready == 1'b1, "R1 ready with response", 64'(cmd_ready), 64'd1);
        for (int k = 0; k < 8; k++)
            chk(obs_oe[k] === 1'b1 && obs_o[k] === exp_hdr[k], "R2 R3 header slot",
                64'({obs_oe[k], obs_o[k]}), 64'({1'b1, exp_hdr[k]}));
        chk(obs_oe[8] === 1'b0, "R4 turnaround before ack", 64'(obs_oe[8]), 64'd0);
        chk(rsp_ack == ack, "R4 acknowledge assembly", 64'(rsp_ack), 64'(ack));
        chk(rsp_proto_err == !legal(ack), "R9 protocol error flag", 64'(rsp_proto_err), 64'(!legal(ack)));
        if (ok && !rnw) begin
            logic [32:0] wexp;
            wexp = {^wd, wd};
            chk(obs_oe[12] === 1'b0, "R5 turnaround before write data", 64'(obs_oe[12]), 64'd0);
            for (int k = 0; k < 33; k++)
                chk(obs_oe[13+k] === 1'b1 && obs_o[13+k] === wexp[k], "R5 write data slot",
                    64'({obs_oe[13+k], obs_o[13+k]}), 64'({1'b1, wexp[k]}));
            chk(rsp_rdata == 32'd0 && !rsp_perr, "R7 no read result on write",
                64'({rsp_perr, rsp_rdata}), 64'd0);
        end else if (ok && rnw) begin
            bit all_in;
            all_in = 1'b1;
            for (int k = 12; k < 46; k++) if (obs_oe[k] !== 1'b0) all_in = 1'b0;
            chk(all_in, "R6 line released during read and trailing turnaround", 64'(all_in), 64'd1);
            chk(rsp_rdata == rd, "R6 read data", 64'(rsp_rdata), 64'(rd));
            chk(rsp_perr == bad_par, "R7 read parity flag", 64'(rsp_perr), 64'(bad_par));
        end else begin
            chk(obs_oe[12] === 1'b0, "R8 turnaround after non-OK ack", 64'(obs_oe[12]), 64'd0);
            chk(rsp_rdata == 32'd0 && !rsp_perr, "R8 no data on non-OK ack",
                64'({rsp_perr, rsp_rdata}), 64'd0);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 response is one cycle", 64'(rsp_valid), 64'd0);
        chk(swclk_en == 1'b0, "R10 clock idle between commands", 64'(swclk_en), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cmd_ready == 1'b1 && swclk_en == 1'b0 && swdio_oe == 1'b0 && rsp_valid == 1'b0,
            "R11 reset state", 64'({cmd_ready, swclk_en, swdio_oe, rsp_valid}), 64'b1000);

        // Directed corner cases
        run_txn(1'b0, 1'b0, 2'b01, 32'hFFFF_FFFF, 3'b001, 32'h0, 1'b0); // R5 all ones
        run_txn(1'b1, 1'b1, 2'b11, 32'h0, 3'b001, 32'h8000_0001, 1'b0); // R6
        run_txn(1'b1, 1'b1, 2'b00, 32'h0, 3'b001, 32'h1234_5678, 1'b1); // R7 corrupted parity
        run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h0, 1'b0);         // R6 zero data
        run_txn(1'b1, 1'b0, 2'b10, 32'hA5A5_5A5A, 3'b010, 32'h0, 1'b0); // R8 WAIT
        run_txn(1'b0, 1'b1, 2'b11, 32'h0, 3'b100, 32'hDEAD_BEEF, 1'b0); // R8 FAULT
        run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b000, 32'h0, 1'b0);         // R9 no response
        run_txn(1'b0, 1'b0, 2'b00, 32'h1, 3'b111, 32'h0, 1'b0);         // R9 all ones

        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            logic [2:0] a;
            int pick;
            pick = int'($urandom % 8);
            if (pick < 4)       a = 3'b001;
            else if (pick == 4) a = 3'b010;
            else if (pick == 5) a = 3'b100;
            else begin
                a = 3'($urandom % 8);
                while (legal(a)) a = 3'($urandom % 8);
            end
            run_txn(1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4),
                    $urandom, a, $urandom, 1'(($urandom % 4) == 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule